// File: doc/BRIEF.md
# Debug and Monitor Access Trap Router

This block decides what happens to a system-register access aimed at the debug, trace, profiling or performance-monitor register groups. It also decides what happens to an access to the hypervisor debug-configuration register itself. Each request carries:

- the current privilege level;
- a register-class code;
- the access direction;
- whether the core is in debug halt state.

The router combines these with the hypervisor trap controls, a host-mode bit, a nested-virtualisation bit and a monitor-level debug-trap bit. One cycle later it returns one of four results (allow, undefined, trap to level 2, trap to level 3) together with a syndrome class.

Some controls are forced on for decision-making while their stored values stay untouched. The block therefore also exposes the effective control values: the forced debug traps and the decoded profiling-buffer ownership. Other logic uses these values, while a direct read of the stored register still sees what software wrote.

Top module: `dbg_trap_router`

## Requirements
- R1: After reset, `rsp_valid` is 0, and `rsp_result` and `rsp_syndrome` are 0. Every request sampled with `req_valid`=1 produces `rsp_valid`=1 on the following cycle. A cycle without a request yields allow with syndrome 0.
- R2: The result codes are 0 = allow, 1 = undefined, 2 = trap to level 2 and 3 = trap to level 3. Both trap results carry syndrome `TRAP_EC` (default 0x18), and the other results carry 0. Undefined outranks a level-3 trap, which outranks a level-2 trap.
- R3: The class codes are 0 debug ROM, 1 OS/powerdown debug, 2 general debug, 3 debug data-transfer, 4 performance monitor, 5 performance control, 6 trace filter, 7 profiling control, 8 profiling buffer and 9 the configuration register. Codes 10 to 15 are undefined at every level.
- R4: With `hyp_en`=1, the following accesses trap to level 2. Debug ROM, general debug and data-transfer accesses from level 0 or 1 trap under their effective trap bit. Performance-monitor accesses from level 0 or 1 trap under `ctl_pmu_trap`. Performance-control accesses from level 0 or 1 trap under `ctl_pmu_trap` or `ctl_pmctl_trap`. OS, trace-filter and profiling-control accesses from level 1 trap under their bit.
- R5: The OS, trace-filter, profiling-control and profiling-buffer classes are undefined from level 0. A write to the debug ROM class is undefined at any level.
- R6: `ctl_route_dbg`=1 or `host_mode`=1 makes the effective ROM, OS and general debug traps 1, and `host_mode`=1 makes `eff_route_dbg` 1. With both at 0, each effective bit equals its stored input.
- R7: With `dbg_halted`=1, data-transfer accesses are not trapped by the general debug trap.
- R8: The profiling-buffer field is decoded as follows: 00 gives trap plus level-2 regime, 10 gives trap plus level-1 regime, 11 gives no trap plus level-1 regime, and the reserved value 01 acts as 00. With `hyp_en`=0 it acts as 11. `pbuf_trap_l1` and `pbuf_l2_regime` show the decoded values, and level-1 buffer accesses trap to level 2 when `pbuf_trap_l1`=1.
- R9: An access to the configuration register is routed by level. Level 0 is undefined. Level 1 traps to level 2 if `hyp_en` and `nested_virt` are both 1, and is undefined otherwise. Level 2 traps to level 3 if `mon_dbg_trap`=1, and is allowed otherwise. Level 3 is allowed.
- R10: Accesses to classes 0 to 8 from level 2 or 3 are allowed, except ROM writes. With `hyp_en`=0 no class 0 to 8 access traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_priv | input | 2 | Privilege level of the access, 0 to 3 |
| req_class | input | 4 | Register-class code (R3) |
| req_write | input | 1 | 1 = write, 0 = read |
| dbg_halted | input | 1 | Debug halt state active |
| hyp_en | input | 1 | Hypervisor level enabled in current security state |
| host_mode | input | 1 | Host-mode bit, forces debug routing |
| nested_virt | input | 1 | Nested-virtualisation bit |
| mon_dbg_trap | input | 1 | Monitor-level debug-trap bit |
| ctl_rom_trap | input | 1 | Stored debug ROM trap bit |
| ctl_os_trap | input | 1 | Stored OS/powerdown debug trap bit |
| ctl_dbg_trap | input | 1 | Stored general debug trap bit |
| ctl_route_dbg | input | 1 | Stored debug-exception routing bit |
| ctl_pmu_trap | input | 1 | Stored performance-monitor trap bit |
| ctl_pmctl_trap | input | 1 | Stored performance-control trap bit |
| ctl_trace_trap | input | 1 | Stored trace-filter trap bit |
| ctl_prof_trap | input | 1 | Stored profiling-control trap bit |
| ctl_pbuf | input | 2 | Stored profiling-buffer field |
| rsp_valid | output | 1 | Result valid |
| rsp_result | output | 2 | Result code (R2) |
| rsp_syndrome | output | SYND_W | Syndrome class |
| eff_rom_trap | output | 1 | Effective debug ROM trap |
| eff_os_trap | output | 1 | Effective OS debug trap |
| eff_dbg_trap | output | 1 | Effective general debug trap |
| eff_route_dbg | output | 1 | Effective debug-exception routing |
| pbuf_trap_l1 | output | 1 | Decoded: level-1 buffer accesses trap |
| pbuf_l2_regime | output | 1 | Decoded: buffer uses level-2 regime |

## Verification
The bench builds the router with its default parameters: a 6-bit syndrome, trap class 0x18 and ten classes. At these values every class code, including the six unused ones, and every level fits in a few thousand random requests. That covers all combinations of forced routing, host mode, halt state and all four buffer encodings together with the configuration-register routing. Directed cases pin the reserved buffer encoding, the halted data-transfer exemption and each level of configuration-register access.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    typedef enum logic [1:0] {
        RES_ALLOW   = 2'd0,
        RES_UNDEF   = 2'd1,
        RES_TRAP_L2 = 2'd2,
        RES_TRAP_L3 = 2'd3
    } res_e;

    localparam int CLASS_W     = 4;
    localparam int NUM_CLASSES = 10;

    localparam logic [CLASS_W-1:0] CL_ROM   = 4'd0;
    localparam logic [CLASS_W-1:0] CL_OSPD  = 4'd1;
    localparam logic [CLASS_W-1:0] CL_DBG   = 4'd2;
    localparam logic [CLASS_W-1:0] CL_DXFER = 4'd3;
    localparam logic [CLASS_W-1:0] CL_PMU   = 4'd4;
    localparam logic [CLASS_W-1:0] CL_PMCTL = 4'd5;
    localparam logic [CLASS_W-1:0] CL_TRACE = 4'd6;
    localparam logic [CLASS_W-1:0] CL_PROF  = 4'd7;
    localparam logic [CLASS_W-1:0] CL_PBUF  = 4'd8;
    localparam logic [CLASS_W-1:0] CL_HCFG  = 4'd9;

    localparam logic [1:0] PBUF_L2_TRAP = 2'b00;
    localparam logic [1:0] PBUF_RSVD    = 2'b01;
    localparam logic [1:0] PBUF_OPEN    = 2'b11;

    typedef struct packed {
        logic       rom;
        logic       os;
        logic       dbg;
        logic       route;
        logic       pmu;
        logic       pmctl;
        logic       trace;
        logic       prof;
        logic [1:0] pbuf;
    } trap_ctl_t;

    typedef struct packed {
        logic undef;
        logic to_l3;
        logic to_l2;
    } verdict_t;

    function automatic verdict_t merge_verdict(verdict_t a, verdict_t b);
        verdict_t m;
        m.undef = a.undef | b.undef;
        m.to_l3 = a.to_l3 | b.to_l3;
        m.to_l2 = a.to_l2 | b.to_l2;
        return m;
    endfunction

    function automatic res_e resolve(verdict_t v);
        if (v.undef)      return RES_UNDEF;
        else if (v.to_l3) return RES_TRAP_L3;
        else if (v.to_l2) return RES_TRAP_L2;
        else              return RES_ALLOW;
    endfunction

    // Class reachable only from level 1 (level 0 makes it undefined).
    function automatic logic l1_only(int unsigned idx);
        return (idx == int'(CL_OSPD)) || (idx == int'(CL_TRACE)) ||
               (idx == int'(CL_PROF)) || (idx == int'(CL_PBUF));
    endfunction

    // Level-2 trap condition of one class for a level 0/1 access.
    function automatic logic class_trap(int unsigned idx, trap_ctl_t e,
                                        logic halted);
        case (idx)
            int'(CL_ROM):   return e.rom;
            int'(CL_OSPD):  return e.os;
            int'(CL_DBG):   return e.dbg;
            int'(CL_DXFER): return e.dbg & ~halted;
            int'(CL_PMU):   return e.pmu;
            int'(CL_PMCTL): return e.pmu | e.pmctl;
            int'(CL_TRACE): return e.trace;
            int'(CL_PROF):  return e.prof;
            int'(CL_PBUF):  return e.pbuf != PBUF_OPEN;
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dtr_ctl_eff.sv
module dtr_ctl_eff
    import dtr_pkg::*;
(
    input  trap_ctl_t raw,
    input  logic      hyp_en,
    input  logic      host_mode,
    output trap_ctl_t eff
);
    logic route_f;

    always_comb begin
        route_f   = raw.route | host_mode;
        eff       = raw;
        eff.route = route_f;
        eff.rom   = raw.rom | route_f;
        eff.os    = raw.os  | route_f;
        eff.dbg   = raw.dbg | route_f;
        if (!hyp_en)
            eff.pbuf = PBUF_OPEN;
        else if (raw.pbuf == PBUF_RSVD)
            eff.pbuf = PBUF_L2_TRAP;
        else
            eff.pbuf = raw.pbuf;
    end
endmodule

// File: rtl/dtr_class_chk.sv
module dtr_class_chk
    import dtr_pkg::*;
(
    input  trap_ctl_t            eff,
    input  logic [1:0]           priv,
    input  logic [CLASS_W-1:0]   cls,
    input  logic                 is_write,
    input  logic                 halted,
    input  logic                 hyp_en,
    output verdict_t             verdict
);
    localparam int SPAN = 1 << CLASS_W;

    logic [SPAN-1:0] hit_vec;
    logic [SPAN-1:0] l0_block_vec;
    logic [SPAN-1:0] known_vec;
    logic            low_priv;

    assign low_priv = (priv == 2'd0) || (priv == 2'd1);

    for (genvar g = 0; g < SPAN; g++) begin : g_cls
        if (g < NUM_CLASSES && g != int'(CL_HCFG)) begin : g_act
            assign known_vec[g]    = 1'b1;
            assign l0_block_vec[g] = l1_only(g);
            assign hit_vec[g]      = class_trap(g, eff, halted);
        end else if (g == int'(CL_HCFG)) begin : g_cfg
            assign known_vec[g]    = 1'b1;
            assign l0_block_vec[g] = 1'b0;
            assign hit_vec[g]      = 1'b0;
        end else begin : g_none
            assign known_vec[g]    = 1'b0;
            assign l0_block_vec[g] = 1'b0;
            assign hit_vec[g]      = 1'b0;
        end
    end

    always_comb begin
        verdict.undef = ~known_vec[cls]
                      | (l0_block_vec[cls] & (priv == 2'd0))
                      | ((cls == CL_ROM) & is_write);
        verdict.to_l3 = 1'b0;
        verdict.to_l2 = hyp_en & low_priv & hit_vec[cls];
    end
endmodule

// File: rtl/dtr_cfg_chk.sv
module dtr_cfg_chk
    import dtr_pkg::*;
(
    input  logic       active,
    input  logic [1:0] priv,
    input  logic       hyp_en,
    input  logic       nested_virt,
    input  logic       mon_dbg_trap,
    output verdict_t   verdict
);
    always_comb begin
        verdict = '0;
        if (active) begin
            case (priv)
                2'd0: verdict.undef = 1'b1;
                2'd1: begin
                    if (hyp_en && nested_virt) verdict.to_l2 = 1'b1;
                    else                       verdict.undef = 1'b1;
                end
                2'd2: verdict.to_l3 = mon_dbg_trap;
                default: verdict = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_trap_router.sv
module dbg_trap_router
    import dtr_pkg::*;
#(
    parameter int                SYND_W  = 6,
    parameter logic [SYND_W-1:0] TRAP_EC = 6'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_priv,
    input  logic [3:0]        req_class,
    input  logic              req_write,
    input  logic              dbg_halted,
    input  logic              hyp_en,
    input  logic              host_mode,
    input  logic              nested_virt,
    input  logic              mon_dbg_trap,
    input  logic              ctl_rom_trap,
    input  logic              ctl_os_trap,
    input  logic              ctl_dbg_trap,
    input  logic              ctl_route_dbg,
    input  logic              ctl_pmu_trap,
    input  logic              ctl_pmctl_trap,
    input  logic              ctl_trace_trap,
    input  logic              ctl_prof_trap,
    input  logic [1:0]        ctl_pbuf,
    output logic              rsp_valid,
    output logic [1:0]        rsp_result,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic              eff_rom_trap,
    output logic              eff_os_trap,
    output logic              eff_dbg_trap,
    output logic              eff_route_dbg,
    output logic              pbuf_trap_l1,
    output logic              pbuf_l2_regime
);
    trap_ctl_t raw_ctl, eff_ctl;
    verdict_t  cls_v, cfg_v, all_v;
    res_e      res_nxt;

    always_comb begin
        raw_ctl.rom   = ctl_rom_trap;
        raw_ctl.os    = ctl_os_trap;
        raw_ctl.dbg   = ctl_dbg_trap;
        raw_ctl.route = ctl_route_dbg;
        raw_ctl.pmu   = ctl_pmu_trap;
        raw_ctl.pmctl = ctl_pmctl_trap;
        raw_ctl.trace = ctl_trace_trap;
        raw_ctl.prof  = ctl_prof_trap;
        raw_ctl.pbuf  = ctl_pbuf;
    end

    dtr_ctl_eff u_eff (
        .raw       (raw_ctl),
        .hyp_en    (hyp_en),
        .host_mode (host_mode),
        .eff       (eff_ctl)
    );

    dtr_class_chk u_cls (
        .eff      (eff_ctl),
        .priv     (req_priv),
        .cls      (req_class),
        .is_write (req_write),
        .halted   (dbg_halted),
        .hyp_en   (hyp_en),
        .verdict  (cls_v)
    );

    dtr_cfg_chk u_cfg (
        .active       (req_class == CL_HCFG),
        .priv         (req_priv),
        .hyp_en       (hyp_en),
        .nested_virt  (nested_virt),
        .mon_dbg_trap (mon_dbg_trap),
        .verdict      (cfg_v)
    );

    assign all_v   = merge_verdict(cls_v, cfg_v);
    assign res_nxt = resolve(all_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_result   <= RES_ALLOW;
            rsp_syndrome <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_result   <= res_nxt;
                rsp_syndrome <= (res_nxt == RES_TRAP_L2 || res_nxt == RES_TRAP_L3)
                                ? TRAP_EC : '0;
            end else begin
                rsp_result   <= RES_ALLOW;
                rsp_syndrome <= '0;
            end
        end
    end

    assign eff_rom_trap   = eff_ctl.rom;
    assign eff_os_trap    = eff_ctl.os;
    assign eff_dbg_trap   = eff_ctl.dbg;
    assign eff_route_dbg  = eff_ctl.route;
    assign pbuf_trap_l1   = eff_ctl.pbuf != PBUF_OPEN;
    assign pbuf_l2_regime = eff_ctl.pbuf == PBUF_L2_TRAP;
endmodule

// File: rtl/dbg_trap_router_chk.sv
module dbg_trap_router_chk #(
    parameter int                SYND_W  = 6,
    parameter logic [SYND_W-1:0] TRAP_EC = 6'h18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_priv,
    input logic [3:0]        req_class,
    input logic              req_write,
    input logic              dbg_halted,
    input logic              hyp_en,
    input logic              host_mode,
    input logic              ctl_route_dbg,
    input logic              rsp_valid,
    input logic [1:0]        rsp_result,
    input logic [SYND_W-1:0] rsp_syndrome,
    input logic              eff_rom_trap,
    input logic              eff_os_trap,
    input logic              eff_dbg_trap,
    input logic              pbuf_trap_l1,
    input logic              pbuf_l2_regime
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_ALLOW: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_result == 2'd0 && rsp_syndrome == '0)); // R1
    AST_SYND_MATCH: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_result[1]) == (rsp_syndrome == TRAP_EC))); // R2
    AST_UNKNOWN_CLASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class >= 4'd10) |=> rsp_result == 2'd1); // R3
    AST_FORCED_DEBUG: assert property (@(posedge clk) disable iff (rst)
        (ctl_route_dbg || host_mode) |-> (eff_rom_trap && eff_os_trap && eff_dbg_trap)); // R6
    AST_HALT_DXFER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dbg_halted && req_class == 4'd3) |=> rsp_result != 2'd2); // R7
    AST_PBUF_OFF: assert property (@(posedge clk) disable iff (rst)
        !hyp_en |-> (!pbuf_trap_l1 && !pbuf_l2_regime)); // R8
    AST_CFG_L0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == 2'd0 && req_class == 4'd9) |=> rsp_result == 2'd1); // R9
    AST_CFG_L3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == 2'd3 && req_class == 4'd9) |=> rsp_result == 2'd0); // R9
    AST_HIGH_ALLOW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv[1] && req_class < 4'd9 &&
         !(req_class == 4'd0 && req_write)) |=> rsp_result == 2'd0); // R10
endmodule

bind dbg_trap_router dbg_trap_router_chk #(.SYND_W(SYND_W), .TRAP_EC(TRAP_EC)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_priv       (req_priv),
    .req_class      (req_class),
    .req_write      (req_write),
    .dbg_halted     (dbg_halted),
    .hyp_en         (hyp_en),
    .host_mode      (host_mode),
    .ctl_route_dbg  (ctl_route_dbg),
    .rsp_valid      (rsp_valid),
    .rsp_result     (rsp_result),
    .rsp_syndrome   (rsp_syndrome),
    .eff_rom_trap   (eff_rom_trap),
    .eff_os_trap    (eff_os_trap),
    .eff_dbg_trap   (eff_dbg_trap),
    .pbuf_trap_l1   (pbuf_trap_l1),
    .pbuf_l2_regime (pbuf_l2_regime)
);

// File: tb/tb_dbg_trap_router.sv
module tb_dbg_trap_router;
    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic       req_valid, req_write, dbg_halted, hyp_en, host_mode, nested_virt, mon_dbg_trap;
    logic [1:0] req_priv, ctl_pbuf;
    logic [3:0] req_class;
    logic       c_rom, c_os, c_dbg, c_route, c_pmu, c_pmctl, c_trace, c_prof;
    logic       rsp_valid;
    logic [1:0] rsp_result;
    logic [5:0] rsp_syndrome;
    logic       e_rom, e_os, e_dbg, e_route, pb_trap, pb_l2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    dbg_trap_router dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
        .req_class(req_class), .req_write(req_write), .dbg_halted(dbg_halted),
        .hyp_en(hyp_en), .host_mode(host_mode), .nested_virt(nested_virt),
        .mon_dbg_trap(mon_dbg_trap), .ctl_rom_trap(c_rom), .ctl_os_trap(c_os),
        .ctl_dbg_trap(c_dbg), .ctl_route_dbg(c_route), .ctl_pmu_trap(c_pmu),
        .ctl_pmctl_trap(c_pmctl), .ctl_trace_trap(c_trace), .ctl_prof_trap(c_prof),
        .ctl_pbuf(ctl_pbuf), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
        .rsp_syndrome(rsp_syndrome), .eff_rom_trap(e_rom), .eff_os_trap(e_os),
        .eff_dbg_trap(e_dbg), .eff_route_dbg(e_route), .pbuf_trap_l1(pb_trap),
        .pbuf_l2_regime(pb_l2)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic int model_result();
        bit force_dbg = c_route | host_mode;
        bit trap;
        bit low = (req_priv <= 2'd1);
        if (req_class >= 4'd10) return 1;                         // R3
        if (req_class == 4'd9) begin                              // R9
            case (req_priv)
                2'd0: return 1;
                2'd1: return (hyp_en && nested_virt) ? 2 : 1;
                2'd2: return mon_dbg_trap ? 3 : 0;
                default: return 0;
            endcase
        end
        if (req_class == 4'd0 && req_write) return 1;             // R5
        if (req_priv == 2'd0 && (req_class == 4'd1 || req_class == 4'd6 ||
            req_class == 4'd7 || req_class == 4'd8)) return 1;    // R5
        if (!low || !hyp_en) return 0;                            // R10
        case (req_class)
            4'd0: trap = c_rom | force_dbg;                       // R4 R6
            4'd1: trap = c_os | force_dbg;
            4'd2: trap = c_dbg | force_dbg;
            4'd3: trap = (c_dbg | force_dbg) & ~dbg_halted;       // R7
            4'd4: trap = c_pmu;
            4'd5: trap = c_pmu | c_pmctl;
            4'd6: trap = c_trace;
            4'd7: trap = c_prof;
            default: trap = (ctl_pbuf != 2'b11);                  // R8
        endcase
        return trap ? 2 : 0;
    endfunction

    task automatic issue(string req);
        int er;
        @(negedge clk);
        req_valid = 1'b1;
        er = model_result();
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " result"}, rsp_result, er);
        check({req, " syndrome (R2)"}, rsp_syndrome, (er >= 2) ? 32'h18 : 0);
        check("R1 rsp_valid", rsp_valid, 1);
    endtask

    task automatic zero_ctl();
        {c_rom, c_os, c_dbg, c_route, c_pmu, c_pmctl, c_trace, c_prof} = '0;
        ctl_pbuf = 2'b11; host_mode = 0; nested_virt = 0; mon_dbg_trap = 0;
        hyp_en = 1; dbg_halted = 0; req_write = 0;
    endtask

    task automatic check_eff(string req);
        bit f = c_route | host_mode;
        bit [1:0] pb = !hyp_en ? 2'b11 : (ctl_pbuf == 2'b01 ? 2'b00 : ctl_pbuf);
        #1;
        check({req, " eff_rom"}, e_rom, c_rom | f);
        check({req, " eff_os"}, e_os, c_os | f);
        check({req, " eff_dbg"}, e_dbg, c_dbg | f);
        check({req, " eff_route"}, e_route, f);
        check("R8 pbuf_trap_l1", pb_trap, pb != 2'b11);
        check("R8 pbuf_l2_regime", pb_l2, pb == 2'b00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        req_valid = 0; req_priv = 0; req_class = 0;
        zero_ctl();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset rsp_valid", rsp_valid, 0);
        check("R1 reset result", rsp_result, 0);
        check("R1 reset syndrome", rsp_syndrome, 0);
        @(negedge clk);
        check("R1 idle result", rsp_result, 0);

        // R9: configuration register by level
        req_class = 4'd9;
        req_priv = 0; issue("R9 cfg L0");
        req_priv = 1; nested_virt = 0; issue("R9 cfg L1 no nest");
        nested_virt = 1; issue("R9 cfg L1 nest");
        hyp_en = 0; issue("R9 cfg L1 hyp off");
        hyp_en = 1;
        req_priv = 2; mon_dbg_trap = 1; issue("R9 cfg L2 mon");
        mon_dbg_trap = 0; issue("R9 cfg L2 open");
        req_priv = 3; mon_dbg_trap = 1; issue("R9 cfg L3");
        zero_ctl();

        // R8: reserved buffer encoding traps and uses level-2 regime
        req_class = 4'd8; req_priv = 1; ctl_pbuf = 2'b01;
        check_eff("R8 rsvd");
        issue("R8 pbuf rsvd");
        hyp_en = 0; check_eff("R8 hyp off"); issue("R8 pbuf hyp off");
        zero_ctl();

        // R7: halted data transfer with forced routing
        req_class = 4'd3; req_priv = 0; host_mode = 1; dbg_halted = 1;
        check_eff("R6 host");
        issue("R7 halted dxfer");
        dbg_halted = 0; issue("R4 dxfer trap");
        zero_ctl();

        // R5: ROM write, level-0 OS access; R3 unknown class
        req_class = 4'd0; req_write = 1; req_priv = 3; issue("R5 rom write");
        req_write = 0; req_class = 4'd1; req_priv = 0; issue("R5 os L0");
        req_class = 4'd12; req_priv = 3; issue("R3 unknown class");
        c_pmctl = 1; req_class = 4'd5; req_priv = 0; issue("R4 pmctl L0");
        c_route = 1; req_class = 4'd0; req_priv = 1; check_eff("R6 route"); issue("R6 rom forced");

        for (int i = 0; i < 3000; i++) begin
            req_priv   = 2'($urandom_range(0, 3));
            req_class  = 4'($urandom_range(0, 15));
            req_write  = 1'($urandom_range(0, 1));
            dbg_halted = 1'($urandom_range(0, 1));
            hyp_en     = ($urandom_range(0, 3) != 0);
            host_mode  = ($urandom_range(0, 3) == 0);
            nested_virt  = 1'($urandom_range(0, 1));
            mon_dbg_trap = 1'($urandom_range(0, 1));
            {c_rom, c_os, c_dbg, c_pmu, c_pmctl, c_trace, c_prof} = 7'($urandom);
            c_route    = ($urandom_range(0, 3) == 0);
            ctl_pbuf   = 2'($urandom_range(0, 3));
            check_eff("R6 random");
            issue("R4 R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule